// File: doc/BRIEF.md
# Conditional Execute and Immediate Operand Unit

This unit sits in the execute stage of a 32-bit load/store core. For each instruction it compares a 4-bit condition selector against the four arithmetic flags (negative, zero, carry, overflow) held in a 32-bit status word. From that comparison it raises an execute-enable, which the rest of the stage uses to let the instruction through or to suppress it.

In parallel, the unit expands an 8-bit constant into a 32-bit operand. The constant is rotated right by twice a 4-bit rotate field, and the carry-out of this rotation is reported as well. When an instruction executes and asks for its flags to be updated, the unit writes new flag values into the status word on the next clock edge. The new values come from the ALU result and from the carry and overflow bits that the ALU supplies. A suppressed instruction changes nothing.

The ALU and the instruction decoder are outside the block. The status word is held here and can be observed directly.

Top module: `pred_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the entire status word to zero.
- R2: Condition codes 0 to 7 select, in order: zero set, zero clear, carry set, carry clear, negative set, negative clear, overflow set, overflow clear. The flags are at status bits 31 (N), 30 (Z), 29 (C) and 28 (V).
- R3: Code 8 is true when C is set and Z is clear. Code 9 is true when C is clear or Z is set.
- R4: Code 10 is true when N equals V, and code 11 when N differs from V. Code 12 is true when Z is clear and N equals V. Code 13 is true when Z is set or N differs from V.
- R5: Code 14 is always true and code 15 is never true.
- R6: `execEnable` is low whenever `instValid` is low, whatever the condition code.
- R7: `immOperand` equals the 8-bit constant, zero-extended to 32 bits and rotated right by 2 × `rotField` bit positions. A rotate field of 0 passes the constant through unchanged.
- R8: `immCarry` equals bit 31 of `immOperand`, so it is 0 whenever the rotate field is 0.
- R9: When `instValid`, `execEnable` and `setFlags` are all high at a rising edge, the flags change after that edge as follows: N takes `aluResult[31]`, Z is set exactly when `aluResult` is zero, C takes `aluCarry` and V takes `aluOverflow`.
- R10: An instruction whose condition is false leaves the status word unchanged, even when `setFlags` is high.
- R11: An executing instruction with `setFlags` low leaves the status word unchanged.
- R12: Status bits 27:0 are never modified by a flag update and stay at their reset value of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | An instruction is present this cycle |
| condField | input | 4 | Condition selector of the instruction |
| immField | input | 8 | 8-bit immediate constant |
| rotField | input | 4 | Rotate field; the rotate amount is twice this value |
| aluResult | input | 32 | Result produced by the ALU |
| aluCarry | input | 1 | Carry produced by the ALU operation |
| aluOverflow | input | 1 | Overflow produced by the ALU operation |
| setFlags | input | 1 | The instruction requests a flag update |
| execEnable | output | 1 | The instruction executes |
| immOperand | output | 32 | Expanded immediate operand |
| immCarry | output | 1 | Carry-out of the immediate rotation |
| statusWord | output | 32 | Current status word, flags in bits 31:28 |

## Verification
The flags feed back into the condition decode, so a corrupted flag register does not stay hidden. It shows up as a wrong `execEnable` in the cycle after the faulty write, for every condition code that depends on the damaged bit. It also appears directly on `statusWord` at that same point.

A write that wrongly escapes suppression appears on the very next edge, which is why the bench reads the status word after each suppressed or non-flag-setting instruction. Errors in the rotation are purely combinational and are visible on `immOperand` and `immCarry` in the same cycle the fields are applied.

// File: rtl/pred_exec_pkg.sv
package pred_exec_pkg;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } condCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic execEn;
    logic flagWe;
  } ctrlStrobes_t;

  // flag order within the 4-bit flag nibble: {N, Z, C, V}
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/pred_exec_ctrl.sv
module pred_exec_ctrl
  import pred_exec_pkg::*;
(
  input  logic         instValid,
  input  logic [3:0]   condField,
  input  logic [3:0]   flags,
  input  logic         setFlags,
  output ctrlStrobes_t strobes
);

  logic n, z, c, v;
  logic condTrue;

  assign n = flags[FLAG_N];
  assign z = flags[FLAG_Z];
  assign c = flags[FLAG_C];
  assign v = flags[FLAG_V];

  always_comb begin
    unique case (condCode_e'(condField))
      CC_EQ: condTrue = z;
      CC_NE: condTrue = !z;
      CC_CS: condTrue = c;
      CC_CC: condTrue = !c;
      CC_MI: condTrue = n;
      CC_PL: condTrue = !n;
      CC_VS: condTrue = v;
      CC_VC: condTrue = !v;
      CC_HI: condTrue = c && !z;
      CC_LS: condTrue = !c || z;
      CC_GE: condTrue = (n == v);
      CC_LT: condTrue = (n != v);
      CC_GT: condTrue = !z && (n == v);
      CC_LE: condTrue = z || (n != v);
      CC_AL: condTrue = 1'b1;
      default: condTrue = 1'b0;
    endcase
  end

  assign strobes.execEn = instValid && condTrue;
  assign strobes.flagWe = instValid && condTrue && setFlags;

endmodule

// File: rtl/pred_exec_dp.sv
module pred_exec_dp
  import pred_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [IMM_W-1:0]  immField,
  input  logic [ROT_W-1:0]  rotField,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  output logic [DATA_W-1:0] immOperand,
  output logic              immCarry,
  output logic [DATA_W-1:0] statusWord
);

  localparam int AMT_W = $clog2(DATA_W);
  localparam int FLAG_LO = DATA_W - 4;

  logic [AMT_W-1:0]    rotAmt;
  logic [DATA_W-1:0]   immWide;
  logic [2*DATA_W-1:0] immPair;
  logic [2*DATA_W-1:0] immShift;
  logic [3:0]          nextFlags;
  logic [DATA_W-1:0]   statusQ;

  // rotate amount is twice the field, modulo the data width
  assign rotAmt   = AMT_W'({rotField, 1'b0});
  assign immWide  = {{(DATA_W-IMM_W){1'b0}}, immField};
  assign immPair  = {immWide, immWide};
  assign immShift = immPair >> rotAmt;
  assign immOperand = immShift[DATA_W-1:0];
  assign immCarry   = immShift[DATA_W-1];

  always_comb begin
    nextFlags         = '0;
    nextFlags[FLAG_N] = aluResult[DATA_W-1];
    nextFlags[FLAG_Z] = (aluResult == '0);
    nextFlags[FLAG_C] = aluCarry & 1'b1;
    nextFlags[FLAG_V] = aluOverflow & 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
    end else if (strobes.flagWe) begin
      statusQ[DATA_W-1:FLAG_LO] <= nextFlags;
    end
  end

  assign statusWord = statusQ;

endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import pred_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [COND_W-1:0] condField,
  input  logic [IMM_W-1:0]  immField,
  input  logic [ROT_W-1:0]  rotField,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic              setFlags,
  output logic              execEnable,
  output logic [DATA_W-1:0] immOperand,
  output logic              immCarry,
  output logic [DATA_W-1:0] statusWord
);

  ctrlStrobes_t strobes;

  pred_exec_ctrl u_ctrl (
    .instValid (instValid),
    .condField (condField),
    .flags     (statusWord[DATA_W-1:DATA_W-4]),
    .setFlags  (setFlags),
    .strobes   (strobes)
  );

  pred_exec_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .immField    (immField),
    .rotField    (rotField),
    .aluResult   (aluResult),
    .aluCarry    (aluCarry),
    .aluOverflow (aluOverflow),
    .immOperand  (immOperand),
    .immCarry    (immCarry),
    .statusWord  (statusWord)
  );

  assign execEnable = strobes.execEn;

endmodule

// File: rtl/pred_exec_checker.sv
module pred_exec_checker (
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic [3:0]  condField,
  input logic [7:0]  immField,
  input logic [3:0]  rotField,
  input logic [31:0] aluResult,
  input logic        aluCarry,
  input logic        aluOverflow,
  input logic        setFlags,
  input logic        execEnable,
  input logic [31:0] immOperand,
  input logic        immCarry,
  input logic [31:0] statusWord
);

  assert_never_R5: assert property (@(posedge clk) disable iff (rst)
    (condField == 4'd15) |-> !execEnable);

  assert_always_R5: assert property (@(posedge clk) disable iff (rst)
    (instValid && condField == 4'd14) |-> execEnable);

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> !execEnable);

  assert_norotate_R7: assert property (@(posedge clk) disable iff (rst)
    (rotField == 4'd0) |-> (immOperand == {24'd0, immField}));

  assert_zero_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (rotField == 4'd0) |-> !immCarry);

  assert_flag_write_R9: assert property (@(posedge clk) disable iff (rst)
    (instValid && execEnable && setFlags) |=>
      (statusWord[31] == $past(aluResult[31])) &&
      (statusWord[30] == ($past(aluResult) == 32'd0)) &&
      (statusWord[29] == $past(aluCarry)) &&
      (statusWord[28] == $past(aluOverflow)));

  // also covers R11
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(instValid && execEnable && setFlags) |=> $stable(statusWord));

  assert_low_bits_R12: assert property (@(posedge clk) disable iff (rst)
    statusWord[27:0] == 28'd0);

endmodule

bind pred_exec_unit pred_exec_checker u_checker (
  .clk         (clk),
  .rst         (rst),
  .instValid   (instValid),
  .condField   (condField),
  .immField    (immField),
  .rotField    (rotField),
  .aluResult   (aluResult),
  .aluCarry    (aluCarry),
  .aluOverflow (aluOverflow),
  .setFlags    (setFlags),
  .execEnable  (execEnable),
  .immOperand  (immOperand),
  .immCarry    (immCarry),
  .statusWord  (statusWord)
);

// File: tb/pred_exec_unit_tb.sv
`timescale 1ns/1ps
module pred_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        instValid;
  logic [3:0]  condField;
  logic [7:0]  immField;
  logic [3:0]  rotField;
  logic [31:0] aluResult;
  logic        aluCarry;
  logic        aluOverflow;
  logic        setFlags;
  logic        execEnable;
  logic [31:0] immOperand;
  logic        immCarry;
  logic [31:0] statusWord;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pred_exec_unit u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .condField(condField),
    .immField(immField), .rotField(rotField), .aluResult(aluResult),
    .aluCarry(aluCarry), .aluOverflow(aluOverflow), .setFlags(setFlags),
    .execEnable(execEnable), .immOperand(immOperand), .immCarry(immCarry),
    .statusWord(statusWord)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit refCond(input logic [3:0] code, input bit n, input bit z,
                                 input bit c, input bit v);
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] refImm(input logic [7:0] imm, input logic [3:0] rot);
    logic [31:0] r;
    r = {24'd0, imm};
    for (int i = 0; i < 2 * rot; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  function automatic string condTag(input logic [3:0] code);
    if (code < 4'd8) return "R2";
    if (code < 4'd10) return "R3";
    if (code < 4'd14) return "R4";
    return "R5";
  endfunction

  task automatic idleInputs();
    instValid = 1'b0; condField = 4'd14; immField = 8'd0; rotField = 4'd0;
    aluResult = 32'd0; aluCarry = 1'b0; aluOverflow = 1'b0; setFlags = 1'b0;
  endtask

  // one instruction cycle: apply at negedge, retire at the next negedge
  task automatic issue(input logic [3:0] cond, input logic [31:0] res,
                       input bit c, input bit v, input bit sf);
    @(negedge clk);
    instValid = 1'b1; condField = cond; aluResult = res;
    aluCarry = c; aluOverflow = v; setFlags = sf;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic loadFlags(input bit n, input bit z, input bit c, input bit v);
    logic [31:0] res;
    res = z ? 32'd0 : (n ? 32'h8000_0010 : 32'h0000_0100);
    issue(4'd14, res, c, v, 1'b1);
    check(statusWord == {n, z, c, v, 28'd0}, "R9", "flag load",
          statusWord, {n, z, c, v, 28'd0});
  endtask

  task automatic testReset();
    loadFlags(1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(statusWord == 32'd0, "R1", "reset clears status", statusWord, 32'd0);
  endtask

  task automatic testConditions();
    for (int f = 0; f < 16; f++) begin
      bit n, z, c, v;
      {n, z, c, v} = 4'(f);
      if (n && z) continue;
      loadFlags(n, z, c, v);
      for (int k = 0; k < 16; k++) begin
        bit exp;
        instValid = 1'b1; condField = 4'(k);
        #1;
        exp = refCond(4'(k), n, z, c, v);
        check(execEnable == exp, condTag(4'(k)), "condition result",
              {31'd0, execEnable}, {31'd0, exp});
      end
      instValid = 1'b0;
    end
  endtask

  task automatic testIdle();
    loadFlags(1'b0, 1'b1, 1'b1, 1'b0);
    instValid = 1'b0;
    for (int k = 0; k < 16; k++) begin
      condField = 4'(k);
      #1;
      check(!execEnable, "R6", "no valid, no enable", {31'd0, execEnable}, 32'd0);
    end
  endtask

  task automatic testImmediate();
    logic [7:0] imms [4] = '{8'hFF, 8'h81, 8'h01, 8'hA5};
    for (int i = 0; i < 4; i++) begin
      for (int r = 0; r < 16; r++) begin
        logic [31:0] e;
        immField = imms[i]; rotField = 4'(r);
        #1;
        e = refImm(imms[i], 4'(r));
        check(immOperand == e, "R7", "rotated immediate", immOperand, e);
        check(immCarry == e[31], "R8", "immediate carry", {31'd0, immCarry}, {31'd0, e[31]});
      end
    end
    immField = 8'hFF; rotField = 4'd0;
    #1;
    check(immCarry == 1'b0, "R8", "carry with zero rotate", {31'd0, immCarry}, 32'd0);
    check(immOperand == 32'h0000_00FF, "R7", "zero rotate passthrough", immOperand, 32'hFF);
  endtask

  task automatic testFlagUpdate();
    loadFlags(1'b0, 1'b0, 1'b0, 1'b0);
    issue(4'd14, 32'h8000_0000, 1'b1, 1'b0, 1'b1);
    check(statusWord == 32'hA000_0000, "R9", "negative result", statusWord, 32'hA000_0000);
    issue(4'd14, 32'd0, 1'b0, 1'b1, 1'b1);
    check(statusWord == 32'h5000_0000, "R9", "zero result", statusWord, 32'h5000_0000);
    // NE is true with Z clear
    loadFlags(1'b0, 1'b0, 1'b0, 1'b0);
    issue(4'd1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    check(statusWord == 32'hB000_0000, "R9", "conditional write", statusWord, 32'hB000_0000);
    check(statusWord[27:0] == 28'd0, "R12", "low bits untouched", statusWord, 32'hB000_0000);
  endtask

  task automatic testSuppressed();
    loadFlags(1'b0, 1'b0, 1'b1, 1'b0);
    issue(4'd0, 32'd0, 1'b0, 1'b1, 1'b1);  // EQ false
    check(statusWord == 32'h2000_0000, "R10", "false condition no write", statusWord, 32'h2000_0000);
    issue(4'd15, 32'h8000_0000, 1'b0, 1'b1, 1'b1);  // NV
    check(statusWord == 32'h2000_0000, "R10", "never condition no write", statusWord, 32'h2000_0000);
  endtask

  task automatic testNoSetFlags();
    loadFlags(1'b1, 1'b0, 1'b0, 1'b1);
    issue(4'd14, 32'd0, 1'b1, 1'b0, 1'b0);
    check(statusWord == 32'h9000_0000, "R11", "setFlags low no write", statusWord, 32'h9000_0000);
    check(statusWord[27:0] == 28'd0, "R12", "low bits zero", statusWord, 32'h9000_0000);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleInputs();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(statusWord == 32'd0, "R1", "status after reset", statusWord, 32'd0);
    check(!execEnable, "R6", "idle after reset", {31'd0, execEnable}, 32'd0);
    testReset();
    testConditions();
    testIdle();
    testImmediate();
    testFlagUpdate();
    testSuppressed();
    testNoSetFlags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule